// File: doc/BRIEF.md
# Four-Plane Frame Buffer Write Datapath

This block sits between a CPU data port and a four-plane frame buffer and turns every CPU byte write into one byte for each plane. A CPU read captures the byte at the same offset in all four planes into four 8-bit latches. A later write can combine the CPU byte with those latched bytes. The output bytes and the write strobes appear in the same cycle as the write request.

Each plane byte passes through three stages. First, the selected write mode forms a data byte: a rotated CPU byte, a byte made from one CPU bit, or a set/reset constant. Second, an optional logical operation combines that byte with the latch. Third, a bit-mask merge keeps the latch value in every bit that is cleared in the mask. One mode skips all of this and copies the latches back to the planes, which makes plane-to-plane block copies possible.

Software sets the mode, rotate, logical operation, set/reset, set/reset enable and bit mask through a small index/data register-write port. A separate 4-bit input chooses which planes get a write strobe. The address is passed straight through to the planes.

Top module: `planar_write_path`

## Requirements
- R1: Register indices are 0 for set/reset (bits 3:0), 1 for set/reset enable (bits 3:0), 2 for rotate count (bits 2:0) with the logical-operation select (bits 4:3), 3 for write mode (bits 1:0) and 4 for bit mask (bits 7:0). A register is written on a rising edge with `cfg_wr` high. A synchronous reset with `rst_n` low clears all registers and latches to zero.
- R2: A rising edge with `cpu_rd` high loads `plane_rdata` into the four latches in one transaction. Plane N's latch takes bits 8N+7:8N, and the new value is visible from the next cycle.
- R3: Latches keep their value on every cycle without `cpu_rd`, whatever writes or register updates occur.
- R4: In write mode 1, each plane byte equals that plane's latch byte, whatever the CPU data, mask or other settings are.
- R5: In write modes 0 and 3, the CPU byte is rotated right by the rotate count. A count of 0 leaves it unchanged.
- R6: In write mode 0, when bit N of set/reset enable is 1, plane N's data byte becomes set/reset bit N copied to all 8 bits.
- R7: In modes 0 and 2, logical-operation select 0 passes the data byte unchanged, 1 ANDs it with the latch, 2 ORs it with the latch and 3 XORs it with the latch.
- R8: In write mode 2, plane N's data byte is all ones when CPU data bit N is 1, and all zeros otherwise.
- R9: In write mode 3, the effective mask is the bit-mask register ANDed with the rotated CPU byte. The data byte is set/reset bit N copied to all 8 bits, and no logical operation is applied.
- R10: The plane byte is (data AND mask) OR (latch AND NOT mask). Every bit cleared in the effective mask equals the latch bit.
- R11: `plane_we` equals `plane_en` while `cpu_wr` is high and is zero otherwise. Plane N's byte is `plane_wdata[8N+7:8N]`, and it is valid combinationally in the same cycle as `cpu_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cpu_addr | input | ADDR_W | CPU plane offset |
| cpu_rd | input | 1 | CPU read; loads the latches |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write byte |
| plane_rdata | input | 32 | Bytes read from the four planes at `cpu_addr` |
| plane_en | input | 4 | Planes allowed to be written |
| plane_addr | output | ADDR_W | Offset presented to every plane |
| plane_we | output | 4 | Per-plane write strobes |
| plane_wdata | output | 32 | Per-plane write bytes |

## Verification
On every cycle, the assertions check the following: strobes are gated by the write request and the plane enable; latches load on a read and hold otherwise; the copy mode reproduces the latches; and the latch value survives in every bit outside the programmed mask. Other behaviour needs a reference value that only the bench's scenarios supply. This covers the rotate amount, set/reset substitution for individual planes, each of the four logical operations, expansion of a plane's own bit, and the data-gated mask of mode 3.

// File: rtl/pwp_pkg.sv
// Shared constants and types for the planar write datapath.
// Assumes four planes of one byte each.
package pwp_pkg;
    localparam int NPLANES = 4;
    localparam int BYTE_W  = 8;
    localparam int BUS_W   = NPLANES * BYTE_W;
    localparam int IDX_W   = 3;

    localparam logic [IDX_W-1:0] IDX_SETRST = 3'd0;
    localparam logic [IDX_W-1:0] IDX_SREN   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_ROTLOP = 3'd2;
    localparam logic [IDX_W-1:0] IDX_MODE   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_MASK   = 3'd4;

    typedef enum logic [1:0] {
        WM_MERGE  = 2'd0,
        WM_COPY   = 2'd1,
        WM_EXPAND = 2'd2,
        WM_MASKED = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        LOP_PASS = 2'd0,
        LOP_AND  = 2'd1,
        LOP_OR   = 2'd2,
        LOP_XOR  = 2'd3
    } lop_e;

    typedef struct packed {
        logic [NPLANES-1:0] setrst;
        logic [NPLANES-1:0] sren;
        logic [2:0]         rot;
        lop_e               lop;
        wmode_e             mode;
        logic [BYTE_W-1:0]  bitmask;
    } gc_cfg_t;
endpackage

// File: rtl/pwp_cfg_regs.sv
// Configuration registers written through an index/data port.
// Assumes one register write per cycle and a synchronous active-low reset to zero.
module pwp_cfg_regs
    import pwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output gc_cfg_t           cfg
);
    logic [NPLANES-1:0] setrst_q;
    logic [NPLANES-1:0] sren_q;
    logic [4:0]         rotlop_q;
    logic [1:0]         mode_q;
    logic [BYTE_W-1:0]  mask_q;

    // Store the byte addressed by the index, or clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setrst_q <= '0;
            sren_q   <= '0;
            rotlop_q <= '0;
            mode_q   <= '0;
            mask_q   <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_SETRST: setrst_q <= wdata[NPLANES-1:0];
                IDX_SREN:   sren_q   <= wdata[NPLANES-1:0];
                IDX_ROTLOP: rotlop_q <= wdata[4:0];
                IDX_MODE:   mode_q   <= wdata[1:0];
                IDX_MASK:   mask_q   <= wdata;
                default: ;
            endcase
        end
    end

    // Present the stored fields as one typed bundle.
    always_comb begin
        cfg.setrst  = setrst_q;
        cfg.sren    = sren_q;
        cfg.rot     = rotlop_q[2:0];
        cfg.lop     = lop_e'(rotlop_q[4:3]);
        cfg.mode    = wmode_e'(mode_q);
        cfg.bitmask = mask_q;
    end
endmodule

// File: rtl/pwp_latch_bank.sv
// Holds one byte per plane, captured from the planes on a CPU read.
// Assumes the plane read data is valid in the cycle that load is high.
module pwp_latch_bank
    import pwp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] latch_q
);
    // Capture all plane bytes together; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (load)
            latch_q <= din;
    end
endmodule

// File: rtl/pwp_plane_lane.sv
// Forms one plane's write byte from the CPU byte, the settings and that plane's latch.
// Purely combinational; PLANE_IDX selects which CPU bit mode 2 expands.
module pwp_plane_lane
    import pwp_pkg::*;
#(
    parameter int PLANE_IDX = 0
) (
    input  wmode_e            mode,
    input  lop_e              lop,
    input  logic [2:0]        rot,
    input  logic [BYTE_W-1:0] bitmask,
    input  logic              setrst_bit,
    input  logic              sren_bit,
    input  logic [BYTE_W-1:0] cpu_data,
    input  logic [BYTE_W-1:0] latch_byte,
    output logic [BYTE_W-1:0] out_byte
);
    logic [2*BYTE_W-1:0] doubled;
    logic [BYTE_W-1:0]   rotated;

    // Rotate right by shifting a doubled copy of the CPU byte.
    always_comb begin
        doubled = {cpu_data, cpu_data} >> rot;
        rotated = doubled[BYTE_W-1:0];
    end

    // Select the mode's data and mask, apply the logical operation, then merge with the latch.
    always_comb begin
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] mask;
        data = rotated;
        mask = bitmask;
        if (mode == WM_EXPAND)
            data = {BYTE_W{cpu_data[PLANE_IDX]}};
        if (mode == WM_MERGE && sren_bit)
            data = {BYTE_W{setrst_bit}};
        if (mode == WM_MASKED) begin
            mask = bitmask & rotated;
            data = {BYTE_W{setrst_bit}};
        end else begin
            case (lop)
                LOP_AND: data = data & latch_byte;
                LOP_OR:  data = data | latch_byte;
                LOP_XOR: data = data ^ latch_byte;
                default: ;
            endcase
        end
        if (mode == WM_COPY)
            out_byte = latch_byte;
        else
            out_byte = (data & mask) | (latch_byte & ~mask);
    end
endmodule

// File: rtl/planar_write_path.sv
// Top of the four-plane write datapath: settings, read latches and one lane per plane.
// Assumes the plane memory returns read data in the same cycle as cpu_rd.
module planar_write_path
    import pwp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [BYTE_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [BYTE_W-1:0]  cpu_wdata,
    input  logic [BUS_W-1:0]   plane_rdata,
    input  logic [NPLANES-1:0] plane_en,
    output logic [ADDR_W-1:0]  plane_addr,
    output logic [NPLANES-1:0] plane_we,
    output logic [BUS_W-1:0]   plane_wdata
);
    gc_cfg_t           cfg;
    logic [BUS_W-1:0]  latch_q;
    logic [BYTE_W-1:0] cur_mask;
    wmode_e            cur_mode;

    pwp_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    pwp_latch_bank u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cpu_rd),
        .din     (plane_rdata),
        .latch_q (latch_q)
    );

    // One lane per plane, each reading its own latch byte and configuration bits.
    for (genvar p = 0; p < NPLANES; p++) begin : g_lane
        pwp_plane_lane #(.PLANE_IDX(p)) u_lane (
            .mode       (cfg.mode),
            .lop        (cfg.lop),
            .rot        (cfg.rot),
            .bitmask    (cfg.bitmask),
            .setrst_bit (cfg.setrst[p]),
            .sren_bit   (cfg.sren[p]),
            .cpu_data   (cpu_wdata),
            .latch_byte (latch_q[p*BYTE_W +: BYTE_W]),
            .out_byte   (plane_wdata[p*BYTE_W +: BYTE_W])
        );
    end

    // Gate the strobes by the request and pass the offset through.
    always_comb begin
        plane_we   = cpu_wr ? plane_en : '0;
        plane_addr = cpu_addr;
        cur_mask   = cfg.bitmask;
        cur_mode   = cfg.mode;
    end
endmodule

// File: rtl/pwp_checker.sv
// Cycle-by-cycle properties of the write datapath, attached to the top by bind.
module pwp_checker
    import pwp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_rd,
    input logic               cpu_wr,
    input logic [NPLANES-1:0] plane_en,
    input logic [BUS_W-1:0]   plane_rdata,
    input logic [NPLANES-1:0] plane_we,
    input logic [BUS_W-1:0]   plane_wdata,
    input logic [BUS_W-1:0]   latch_q,
    input logic [BYTE_W-1:0]  cur_mask,
    input wmode_e             cur_mode
);
    // R11
    strobe_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_we & ~plane_en) == '0);

    // R11
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> plane_we == '0);

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_rd)) |-> latch_q == $past(plane_rdata));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cpu_rd)) |-> $stable(latch_q));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> latch_q == '0);

    // R4
    copy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cur_mode == WM_COPY) |-> plane_wdata == latch_q);

    // R10
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> ((plane_wdata ^ latch_q) & ~{NPLANES{cur_mask}}) == '0);
endmodule

bind planar_write_path pwp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .plane_en    (plane_en),
    .plane_rdata (plane_rdata),
    .plane_we    (plane_we),
    .plane_wdata (plane_wdata),
    .latch_q     (latch_q),
    .cur_mask    (cur_mask),
    .cur_mode    (cur_mode)
);

// File: tb/planar_write_path_bench.sv
module planar_write_path_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [31:0] plane_rdata = '0;
    logic [3:0]  plane_en = '0;
    logic [15:0] plane_addr;
    logic [3:0]  plane_we;
    logic [31:0] plane_wdata;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    planar_write_path u_planar_write_path (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .plane_rdata(plane_rdata),
        .plane_en(plane_en), .plane_addr(plane_addr), .plane_we(plane_we),
        .plane_wdata(plane_wdata)
    );

    // Vector: {mode[62:61], rot[60:58], lop[57:56], sren[55:52], setrst[51:48], mask[47:40], latch[39:8], cpu[7:0]}
    localparam int NVEC = 12;
    localparam logic [62:0] VECS [NVEC] = '{
        {2'd0, 3'd3, 2'd0, 4'h0, 4'h0, 8'hFF, 32'h00000000, 8'h96},
        {2'd0, 3'd7, 2'd0, 4'h0, 4'h0, 8'hFF, 32'h12345678, 8'h81},
        {2'd0, 3'd0, 2'd0, 4'h5, 4'h1, 8'hFF, 32'h00000000, 8'h3C},
        {2'd0, 3'd0, 2'd1, 4'h0, 4'h0, 8'hFF, 32'hF00F33CC, 8'h5A},
        {2'd0, 3'd0, 2'd2, 4'h0, 4'h0, 8'hFF, 32'hF00F33CC, 8'h5A},
        {2'd0, 3'd0, 2'd3, 4'h0, 4'h0, 8'hFF, 32'hF00F33CC, 8'h5A},
        {2'd0, 3'd2, 2'd3, 4'hA, 4'hE, 8'h0F, 32'hA5C3E781, 8'h77},
        {2'd2, 3'd5, 2'd0, 4'hF, 4'h0, 8'hFF, 32'h11223344, 8'h0A},
        {2'd2, 3'd0, 2'd3, 4'h0, 4'h0, 8'hF0, 32'h0F0F0F0F, 8'h05},
        {2'd3, 3'd1, 2'd3, 4'h0, 4'h9, 8'hFF, 32'h5555AAAA, 8'hC3},
        {2'd3, 3'd0, 2'd1, 4'hF, 4'h6, 8'h3C, 32'h00FF00FF, 8'hFF},
        {2'd1, 3'd4, 2'd3, 4'hF, 4'hF, 8'h00, 32'hDEADBEEF, 8'h42}
    };

    // Reference plane byte written from the requirement text.
    function automatic logic [7:0] ref_byte(input logic [62:0] v, input int n);
        logic [1:0] md = v[62:61];
        logic [2:0] rt = v[60:58];
        logic [1:0] lp = v[57:56];
        logic [7:0] lt = v[8*n+8 +: 8];
        logic [7:0] c  = v[7:0];
        logic [7:0] m  = v[47:40];
        logic [7:0] r  = c;
        logic [7:0] d;
        for (int k = 0; k < 8; k++) r[k] = c[(k + rt) % 8];
        if (md == 2'd1) return lt;
        if (md == 2'd3) begin
            m = m & r;
            d = v[48+n] ? 8'hFF : 8'h00;
        end else begin
            if (md == 2'd2) d = c[n] ? 8'hFF : 8'h00;
            else d = v[52+n] ? (v[48+n] ? 8'hFF : 8'h00) : r;
            if (lp == 2'd1) d = d & lt;
            else if (lp == 2'd2) d = d | lt;
            else if (lp == 2'd3) d = d ^ lt;
        end
        return (d & m) | (lt & ~m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_reg(input logic [2:0] idx, input logic [7:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_latch(input logic [31:0] val);
        @(negedge clk);
        cpu_rd = 1'b1; plane_rdata = val;
        @(negedge clk);
        cpu_rd = 1'b0; plane_rdata = 32'hFFFF_FFFF;
    endtask

    // Drive one write and sample the combinational result mid-cycle.
    task automatic do_write(input logic [7:0] val, input logic [3:0] en,
                            output logic [31:0] data, output logic [3:0] we);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = val; plane_en = en;
        #2;
        data = plane_wdata; we = plane_we;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  w;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: after reset mode 0 with mask 0 reproduces zero latches
        do_write(8'hA7, 4'hF, d, w);
        check("R1 reset state data", d, 32'h0);
        check("R11 strobes follow plane_en", {28'h0, w}, 32'hF);

        // Table walk: R5 R6 R7 R8 R9 R10 R4
        for (int i = 0; i < NVEC; i++) begin
            set_reg(3'd3, {6'd0, VECS[i][62:61]});
            set_reg(3'd2, {3'd0, VECS[i][57:56], VECS[i][60:58]});
            set_reg(3'd1, {4'd0, VECS[i][55:52]});
            set_reg(3'd0, {4'd0, VECS[i][51:48]});
            set_reg(3'd4, VECS[i][47:40]);
            load_latch(VECS[i][39:8]);
            for (int n = 0; n < 4; n++) exp[8*n +: 8] = ref_byte(VECS[i], n);
            do_write(VECS[i][7:0], 4'hF, d, w);
            check($sformatf("R5-R10 vector %0d", i), d, exp);
        end

        // R5: rotate 0 passes, rotate 1 moves bit 0 to bit 7
        set_reg(3'd3, 8'd0); set_reg(3'd1, 8'd0); set_reg(3'd4, 8'hFF);
        set_reg(3'd2, 8'd0);
        do_write(8'hA5, 4'hF, d, w);
        check("R5 rotate zero", d, 32'hA5A5A5A5);
        set_reg(3'd2, 8'd1);
        do_write(8'h01, 4'hF, d, w);
        check("R5 rotate one", d, 32'h80808080);

        // R4 and R3: latches survive writes and register changes
        load_latch(32'hCAFE1234);
        set_reg(3'd4, 8'h00); set_reg(3'd0, 8'h0F);
        do_write(8'h55, 4'h3, d, w);
        set_reg(3'd3, 8'd1);
        do_write(8'h00, 4'hF, d, w);
        check("R3 R4 latch held and copied", d, 32'hCAFE1234);

        // R11: no write request gives no strobes; subset of enables
        @(negedge clk);
        cpu_wr = 1'b0; plane_en = 4'hF; #2;
        check("R11 idle strobes", {28'h0, plane_we}, 32'h0);
        do_write(8'h00, 4'h6, d, w);
        check("R11 partial enable", {28'h0, w}, 32'h6);

        // R2: new read replaces all latches
        load_latch(32'h0BADF00D);
        do_write(8'h00, 4'hF, d, w);
        check("R2 latch reload", d, 32'h0BADF00D);

        // R1: reset clears registers and latches
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        set_reg(3'd4, 8'hFF);
        do_write(8'h3C, 4'hF, d, w);
        check("R1 reset clears mode and latches", d, 32'h3C3C3C3C);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule